// File: doc/BRIEF.md
# Temperature Monitor Conversion and Alert Controller

This block is the digital control core of a remote-diode temperature monitor. A host reaches it through a small command-coded register port. Through that port the host sets a configuration byte, reads a status byte and requests single conversions. The block paces an external analog-to-digital converter with a start/done/data handshake. It can run conversions on a periodic timer, or it can run them only on request. Each result is compared against a high limit and a low limit supplied on input pins.

Out-of-range results and an open-diode fault set sticky flags. Reading the status byte clears those flags. While any flag is set, the block pulls an active-low alert line. It also answers an alert-response query, unless a quiet bit in the configuration suppresses both. The quiet bit never erases the latched flags.

Top module: `tmon_ctrl`

## Requirements
- R1: After synchronous reset, the configuration byte reads 0x00 and the status byte reads 0x00. `alert_n` is 1, `cv_start` is 0 and `ara_ack` is 0. The block is in timed mode from reset.
- R2: Command 0x09 on a write stores configuration bits 7 (quiet) and 6 (standby) and discards bits 5:0. Command 0x03 on a read returns the configuration with bits 5:0 as zero. A read with 0x09 or with any undefined code returns 0x00. A write with 0x03 leaves the configuration unchanged. Read data appears on `reg_rdata` in the cycle after the `reg_rd` edge.
- R3: The status byte is read with command 0x02. Bit 7 is busy, bit 4 is the hot flag, bit 3 is the cold flag and bit 2 is the open-probe flag. Bits 6, 5, 1 and 0 read 0. Busy is 1 from the cycle in which `cv_start` is high until the edge at which `cv_done` is accepted.
- R4: With standby at 0, `cv_start` is a one-cycle pulse issued every PERIOD_CYC cycles. The first pulse comes PERIOD_CYC cycles after the write edge that cleared standby. A timer expiry while a conversion is running is dropped. With standby at 1, the timer issues no starts.
- R5: A configuration write that changes standby from 0 to 1 abandons any running conversion at that edge. Busy reads 0 afterwards, and a later `cv_done` changes no flag.
- R6: A write with command 0x0F starts exactly one conversion in either mode when no conversion is running. `cv_start` is high in the cycle after the write edge. The command is ignored while busy.
- R7: An accepted result strictly greater than `hi_limit` sets the hot flag. A result strictly less than `lo_limit` sets the cold flag. Equality sets neither flag. Both comparisons are unsigned.
- R8: Flags are sticky across later in-range results. A status read returns the flags and clears them. A result accepted at the same edge as the status read survives the clear. A condition that persists sets its flag again at the next conversion.
- R9: If `probe_fault` is 1 when `cv_done` is accepted, the open-probe flag sets and that result is not compared against either limit.
- R10: `alert_n` is 0 while any flag is set and quiet is 0. It is 1 whenever quiet is 1. Writing quiet does not clear any flag.
- R11: `ara_ack` is 1 for one cycle after a cycle with `ara_query` high, but only if quiet was 0 and a flag was set in that cycle. Otherwise it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Command code |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| hi_limit | input | DW | High temperature limit |
| lo_limit | input | DW | Low temperature limit |
| cv_start | output | 1 | Converter start pulse |
| cv_done | input | 1 | Converter result valid |
| cv_data | input | DW | Converter result |
| probe_fault | input | 1 | Diode connection fault indication |
| alert_n | output | 1 | Active-low alert line |
| ara_query | input | 1 | Alert-response query strobe |
| ara_ack | output | 1 | Alert-response acknowledge |

## Verification
The bound checker watches the following on every cycle:
- `cv_start` stays a single-cycle pulse, and busy is high whenever it is.
- A stop write leaves nothing busy.
- Standby produces starts only from the single-shot command.
- Quiet holds the alert line high.
- The flags change only through a result or a status read.

The following can only be shown by the bench's scenarios, because they depend on exact cycle counts and on result values:
- The timer period and where it restarts.
- The strict limit comparisons, including equal and inverted limits.
- A late `cv_done` being discarded after a stop.
- The set-beats-clear ordering at a simultaneous read.
- The acknowledge depending on both quiet and the flags.

// File: rtl/tmon_pkg.sv
package tmon_pkg;

    localparam int REG_W = 8;
    localparam int CMD_W = 8;

    localparam logic [CMD_W-1:0] CMD_STS_RD  = 8'h02;
    localparam logic [CMD_W-1:0] CMD_CFG_RD  = 8'h03;
    localparam logic [CMD_W-1:0] CMD_CFG_WR  = 8'h09;
    localparam logic [CMD_W-1:0] CMD_ONESHOT = 8'h0F;

    localparam int BIT_BUSY    = 7;
    localparam int BIT_HOT     = 4;
    localparam int BIT_COLD    = 3;
    localparam int BIT_OPEN    = 2;
    localparam int BIT_QUIET   = 7;
    localparam int BIT_STANDBY = 6;

    typedef struct packed {
        logic quiet;
        logic standby;
    } cfg_t;

    typedef struct packed {
        logic hot;
        logic cold;
        logic open_probe;
    } flags_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_CONV = 1'b1
    } seq_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_STS_RD,
        OP_CFG_RD,
        OP_CFG_WR,
        OP_ONESHOT,
        OP_OTHER
    } op_e;

    function automatic op_e decode_wr(logic wr, logic [CMD_W-1:0] cmd);
        op_e op;
        if (!wr)                    op = OP_NONE;
        else if (cmd == CMD_CFG_WR) op = OP_CFG_WR;
        else if (cmd == CMD_ONESHOT) op = OP_ONESHOT;
        else                        op = OP_OTHER;
        return op;
    endfunction

    function automatic op_e decode_rd(logic rd, logic [CMD_W-1:0] cmd);
        op_e op;
        if (!rd)                    op = OP_NONE;
        else if (cmd == CMD_STS_RD) op = OP_STS_RD;
        else if (cmd == CMD_CFG_RD) op = OP_CFG_RD;
        else                        op = OP_OTHER;
        return op;
    endfunction

    function automatic cfg_t unpack_cfg(logic [REG_W-1:0] d);
        cfg_t c;
        c.quiet   = d[BIT_QUIET];
        c.standby = d[BIT_STANDBY];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_cfg(cfg_t c);
        logic [REG_W-1:0] d;
        d = '0;
        d[BIT_QUIET]   = c.quiet;
        d[BIT_STANDBY] = c.standby;
        return d;
    endfunction

    function automatic logic [REG_W-1:0] pack_status(logic busy, flags_t f);
        logic [REG_W-1:0] d;
        d = '0;
        d[BIT_BUSY] = busy;
        d[BIT_HOT]  = f.hot;
        d[BIT_COLD] = f.cold;
        d[BIT_OPEN] = f.open_probe;
        return d;
    endfunction

    function automatic logic any_flag(flags_t f);
        return f.hot | f.cold | f.open_probe;
    endfunction

endpackage

// File: rtl/tmon_regs.sv
module tmon_regs
    import tmon_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [CMD_W-1:0] reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             busy,
    input  flags_t           flags,
    output cfg_t             cfg,
    output logic             oneshot_req,
    output logic             abort_req,
    output logic             status_clr,
    output logic [REG_W-1:0] reg_rdata
);

    op_e              wr_op;
    op_e              rd_op;
    cfg_t             cfg_next;
    logic [REG_W-1:0] rd_value;

    always_comb begin
        wr_op    = decode_wr(reg_wr, reg_addr);
        rd_op    = decode_rd(reg_rd, reg_addr);
        cfg_next = unpack_cfg(reg_wdata);
        case (rd_op)
            OP_STS_RD: rd_value = pack_status(busy, flags);
            OP_CFG_RD: rd_value = pack_cfg(cfg);
            default:   rd_value = '0;
        endcase
    end

    assign oneshot_req = (wr_op == OP_ONESHOT);
    assign abort_req   = (wr_op == OP_CFG_WR) && cfg_next.standby && !cfg.standby;
    assign status_clr  = (rd_op == OP_STS_RD);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= '0;
            reg_rdata <= '0;
        end else begin
            if (wr_op == OP_CFG_WR) begin
                cfg <= cfg_next;
            end
            if (rd_op != OP_NONE) begin
                reg_rdata <= rd_value;
            end
        end
    end

endmodule

// File: rtl/tmon_sched.sv
module tmon_sched
    import tmon_pkg::*;
#(
    parameter int PERIOD_CYC = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic standby,
    input  logic oneshot_req,
    input  logic abort_req,
    input  logic cv_done,
    output logic cv_start,
    output logic busy,
    output logic done_accept
);

    localparam int TW = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;

    logic tick;
    logic req;
    seq_e state;

    generate
        if (PERIOD_CYC <= 1) begin : g_every
            assign tick = !standby;
        end else begin : g_count
            localparam logic [TW-1:0] LAST = TW'(PERIOD_CYC - 1);
            logic [TW-1:0] tcnt;
            always_ff @(posedge clk) begin
                if (rst || standby || tcnt == LAST) begin
                    tcnt <= '0;
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
            end
            assign tick = !standby && (tcnt == LAST);
        end
    endgenerate

    assign req         = (tick || oneshot_req) && (state == SEQ_IDLE) && !abort_req;
    assign busy        = (state == SEQ_CONV);
    assign done_accept = busy && cv_done && !abort_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SEQ_IDLE;
            cv_start <= 1'b0;
        end else begin
            cv_start <= req;
            if (abort_req) begin
                state <= SEQ_IDLE;
            end else if (req) begin
                state <= SEQ_CONV;
            end else if (busy && cv_done) begin
                state <= SEQ_IDLE;
            end
        end
    end

endmodule

// File: rtl/tmon_eval.sv
module tmon_eval
    import tmon_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          done_accept,
    input  logic [DW-1:0] cv_data,
    input  logic          probe_fault,
    input  logic [DW-1:0] hi_limit,
    input  logic [DW-1:0] lo_limit,
    input  logic          status_clr,
    output flags_t        flags
);

    logic   above;
    logic   below;
    flags_t kept;
    flags_t hit;

    always_comb begin
        above = cv_data > hi_limit;
        below = cv_data < lo_limit;
        kept  = status_clr ? flags_t'('0) : flags;
        hit   = '0;
        if (done_accept) begin
            if (probe_fault) begin
                hit.open_probe = 1'b1;
            end else begin
                hit.hot  = above;
                hit.cold = below;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags <= kept | hit;
        end
    end

endmodule

// File: rtl/tmon_alert.sv
module tmon_alert
    import tmon_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  flags_t flags,
    input  logic   quiet,
    input  logic   ara_query,
    output logic   alert_n,
    output logic   ara_ack
);

    logic pending;

    assign pending = any_flag(flags) && !quiet;
    assign alert_n = !pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            ara_ack <= 1'b0;
        end else begin
            ara_ack <= ara_query && pending;
        end
    end

endmodule

// File: rtl/tmon_ctrl.sv
module tmon_ctrl
    import tmon_pkg::*;
#(
    parameter int DW         = 8,
    parameter int PERIOD_CYC = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [CMD_W-1:0] reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [DW-1:0]    hi_limit,
    input  logic [DW-1:0]    lo_limit,
    output logic             cv_start,
    input  logic             cv_done,
    input  logic [DW-1:0]    cv_data,
    input  logic             probe_fault,
    output logic             alert_n,
    input  logic             ara_query,
    output logic             ara_ack
);

    cfg_t   cfg;
    flags_t flags;
    logic   seq_busy;
    logic   oneshot_req;
    logic   abort_req;
    logic   status_clr;
    logic   done_accept;

    tmon_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .busy        (seq_busy),
        .flags       (flags),
        .cfg         (cfg),
        .oneshot_req (oneshot_req),
        .abort_req   (abort_req),
        .status_clr  (status_clr),
        .reg_rdata   (reg_rdata)
    );

    tmon_sched #(.PERIOD_CYC(PERIOD_CYC)) u_sched (
        .clk         (clk),
        .rst         (rst),
        .standby     (cfg.standby),
        .oneshot_req (oneshot_req),
        .abort_req   (abort_req),
        .cv_done     (cv_done),
        .cv_start    (cv_start),
        .busy        (seq_busy),
        .done_accept (done_accept)
    );

    tmon_eval #(.DW(DW)) u_eval (
        .clk         (clk),
        .rst         (rst),
        .done_accept (done_accept),
        .cv_data     (cv_data),
        .probe_fault (probe_fault),
        .hi_limit    (hi_limit),
        .lo_limit    (lo_limit),
        .status_clr  (status_clr),
        .flags       (flags)
    );

    tmon_alert u_alert (
        .clk       (clk),
        .rst       (rst),
        .flags     (flags),
        .quiet     (cfg.quiet),
        .ara_query (ara_query),
        .alert_n   (alert_n),
        .ara_ack   (ara_ack)
    );

endmodule

// File: rtl/tmon_ctrl_chk.sv
module tmon_ctrl_chk
    import tmon_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [CMD_W-1:0] reg_addr,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic             cv_start,
    input logic             busy,
    input logic             standby,
    input logic             quiet,
    input logic             oneshot_req,
    input logic             status_clr,
    input logic             done_accept,
    input logic [2:0]       flag_bits,
    input logic             alert_n,
    input logic             ara_query,
    input logic             ara_ack
);

    assert_start_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        cv_start |=> !cv_start);

    assert_start_busy_R3: assert property (@(posedge clk) disable iff (rst)
        cv_start |-> busy);

    assert_stop_abandons_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == CMD_CFG_WR && reg_wdata[BIT_STANDBY] && !standby)
        |=> (!busy && !cv_start));

    assert_standby_single_R6: assert property (@(posedge clk) disable iff (rst)
        (cv_start && $past(standby)) |-> $past(oneshot_req));

    assert_quiet_pin_R10: assert property (@(posedge clk) disable iff (rst)
        quiet |-> alert_n);

    assert_alert_active_R10: assert property (@(posedge clk) disable iff (rst)
        (!quiet && flag_bits != 3'b000) |-> !alert_n);

    assert_ack_needs_query_R11: assert property (@(posedge clk) disable iff (rst)
        ara_ack |-> $past(ara_query));

    assert_status_reserved_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == CMD_STS_RD) |=> (reg_rdata[6:5] == 2'b00 && reg_rdata[1:0] == 2'b00));

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (status_clr && !done_accept) |=> (flag_bits == 3'b000));

    assert_flags_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (!status_clr && !done_accept) |=> $stable(flag_bits));

endmodule

bind tmon_ctrl tmon_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .cv_start    (cv_start),
    .busy        (seq_busy),
    .standby     (cfg.standby),
    .quiet       (cfg.quiet),
    .oneshot_req (oneshot_req),
    .status_clr  (status_clr),
    .done_accept (done_accept),
    .flag_bits   (flags),
    .alert_n     (alert_n),
    .ara_query   (ara_query),
    .ara_ack     (ara_ack)
);

// File: tb/sim_tmon_ctrl.sv
`timescale 1ns/1ps
module sim_tmon_ctrl;

    localparam int DW = 8;
    localparam int P  = 24;
    localparam logic [7:0] C_STS = 8'h02;
    localparam logic [7:0] C_CRD = 8'h03;
    localparam logic [7:0] C_CWR = 8'h09;
    localparam logic [7:0] C_ONE = 8'h0F;
    localparam int NV = 8;
    // {hi, lo, result, fault, expected status}
    localparam logic [39:0] VECS [NV] = '{
        40'h64_14_65_00_10,
        40'h64_14_64_00_00,
        40'h64_14_14_00_00,
        40'h64_14_13_00_08,
        40'h64_14_3C_01_04,
        40'h64_14_C8_01_04,
        40'h30_50_40_00_18,
        40'hFF_00_FF_00_00
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic [DW-1:0] hi_limit = '0;
    logic [DW-1:0] lo_limit = '0;
    logic          cv_start;
    logic          cv_done = 1'b0;
    logic [DW-1:0] cv_data = '0;
    logic          probe_fault = 1'b0;
    logic          alert_n;
    logic          ara_query = 1'b0;
    logic          ara_ack;

    int checks = 0;
    int errs   = 0;
    logic [7:0] v;
    int nstart;
    int first_k;
    int second_k;

    always #2 clk = ~clk;

    tmon_ctrl #(.DW(DW), .PERIOD_CYC(P)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hi_limit(hi_limit), .lo_limit(lo_limit), .cv_start(cv_start),
        .cv_done(cv_done), .cv_data(cv_data), .probe_fault(probe_fault),
        .alert_n(alert_n), .ara_query(ara_query), .ara_ack(ara_ack)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] cmd, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = cmd; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] cmd, output logic [7:0] d);
        reg_rd = 1'b1; reg_addr = cmd;
        step();
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic convert(input logic [7:0] d, input logic f);
        cv_done = 1'b1; cv_data = d; probe_fault = f;
        step();
        cv_done = 1'b0; probe_fault = 1'b0;
    endtask

    task automatic ara(output logic a);
        ara_query = 1'b1;
        step();
        ara_query = 1'b0;
        a = ara_ack;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic a;
        repeat (3) step();
        rst = 1'b0;

        // R1 reset state
        chk("R1 alert_n", alert_n, 1);
        chk("R1 cv_start", cv_start, 0);
        chk("R1 ara_ack", ara_ack, 0);
        rd(C_CRD, v); chk("R1 config", v, 8'h00);
        rd(C_STS, v); chk("R1 status", v, 8'h00);

        // R2 command codes
        wr(C_CWR, 8'hFF);
        rd(C_CRD, v); chk("R2 config reserved bits", v, 8'hC0);
        rd(C_CWR, v); chk("R2 read via write code", v, 8'h00);
        wr(C_CRD, 8'h00);
        rd(C_CRD, v); chk("R2 write via read code ignored", v, 8'hC0);
        rd(8'h55, v); chk("R2 undefined code", v, 8'h00);
        wr(C_CWR, 8'h40);
        rd(C_CRD, v); chk("R2 config standby only", v, 8'h40);

        // R4 timed mode, timer restarts at exit from standby
        hi_limit = 8'd200; lo_limit = 8'd10;
        wr(C_CWR, 8'h00);
        nstart = 0; first_k = 0; second_k = 0;
        for (int k = 1; k <= 2 * P + 2; k++) begin
            cv_done = (k == P + 3);
            cv_data = 8'd50;
            step();
            if (cv_start) begin
                nstart++;
                if (nstart == 1) first_k = k;
                if (nstart == 2) second_k = k;
            end
        end
        cv_done = 1'b0;
        chk("R4 start count", nstart, 2);
        chk("R4 first start cycle", first_k, P);
        chk("R4 second start cycle", second_k, 2 * P);
        rd(C_STS, v); chk("R3 busy during conversion", v, 8'h80);

        // R5 stop abandons
        wr(C_CWR, 8'h40);
        rd(C_STS, v); chk("R5 busy cleared by stop", v, 8'h00);
        convert(8'd250, 1'b0);
        rd(C_STS, v); chk("R5 late done ignored", v, 8'h00);
        nstart = 0;
        for (int k = 0; k < 2 * P; k++) begin
            step();
            if (cv_start) nstart++;
        end
        chk("R4 no timer starts in standby", nstart, 0);

        // R6 single shot
        wr(C_ONE, 8'h00);
        chk("R6 single start", cv_start, 1);
        wr(C_ONE, 8'h00);
        chk("R6 ignored while busy", cv_start, 0);
        rd(C_STS, v); chk("R3 busy after single start", v, 8'h80);
        convert(8'd50, 1'b0);
        rd(C_STS, v); chk("R6 returns to idle", v, 8'h00);
        nstart = 0;
        for (int k = 0; k < 2 * P; k++) begin
            step();
            if (cv_start) nstart++;
        end
        chk("R6 exactly one conversion", nstart, 0);

        // R7 R9 R8 vector walk
        for (int i = 0; i < NV; i++) begin
            hi_limit = VECS[i][39:32];
            lo_limit = VECS[i][31:24];
            wr(C_ONE, 8'h00);
            convert(VECS[i][23:16], VECS[i][8]);
            chk("R10 alert follows flags", alert_n, (VECS[i][7:0] == 8'h00));
            rd(C_STS, v); chk("R7/R9 status after result", v, VECS[i][7:0]);
            rd(C_STS, v); chk("R8 read clears", v, 8'h00);
        end

        // R8 stickiness and set-beats-clear
        hi_limit = 8'd100; lo_limit = 8'd20;
        wr(C_ONE, 8'h00); convert(8'd101, 1'b0);
        wr(C_ONE, 8'h00); convert(8'd50, 1'b0);
        rd(C_STS, v); chk("R8 sticky over in-range", v, 8'h10);
        wr(C_ONE, 8'h00); convert(8'd101, 1'b0);
        wr(C_ONE, 8'h00);
        reg_rd = 1'b1; reg_addr = C_STS; cv_done = 1'b1; cv_data = 8'd101;
        step();
        reg_rd = 1'b0; cv_done = 1'b0;
        chk("R8 read data before same-edge result", reg_rdata, 8'h90);
        rd(C_STS, v); chk("R8 same-edge result survives", v, 8'h10);

        // R10 R11 quiet and alert response
        wr(C_ONE, 8'h00); convert(8'd101, 1'b0);
        chk("R10 alert asserted", alert_n, 0);
        ara(a); chk("R11 ack when pending", a, 1);
        step(); chk("R11 ack one cycle", ara_ack, 0);
        wr(C_CWR, 8'hC0);
        chk("R10 quiet releases pin", alert_n, 1);
        ara(a); chk("R11 no ack when quiet", a, 0);
        wr(C_CWR, 8'h40);
        chk("R10 quiet kept flags", alert_n, 0);
        rd(C_STS, v); chk("R10 flags after quiet toggle", v, 8'h10);
        chk("R10 alert released after read", alert_n, 1);
        ara(a); chk("R11 no ack without flag", a, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule